// File: doc/BRIEF.md
# I2C Real-Time-Clock Transaction Snooper

This block is a passive observer placed after an I2C bus decoder. It never touches the bus. It receives one decoded bus event per valid cycle: start, repeated start, stop, address byte for a write, address byte for a read, written data byte or read data byte. From this stream it follows the register transactions that a host runs against a real-time-clock slave. A write burst is the slave address for writing, then a register pointer byte, then data bytes. A read burst puts a repeated start and the slave address for reading after the pointer byte, and the slave then returns data bytes.

Each data byte lands in the register that an internal pointer selects, and the pointer advances after every byte. The block keeps a masked BCD copy of seconds, minutes, hours, day, weekday, month and year, together with a binary equivalent of each. It also keeps the voltage-low bit and the five bits of the second control register. At the stop condition it emits a one-cycle strobe that says whether the burst was a write or a read. Per-field valid bits show which parts of the timestamp that burst refreshed. Traffic to any other slave address is dropped.

Top module: `rtc_snoop`

## Requirements
- R1: After a synchronous active-low reset, every field, valid bit, control bit, the voltage-low bit, the error flag and both strobes read zero.
- R2: Before a start event is seen, data, address and stop events leave every output unchanged.
- R3: A write burst has these events in order: start, address-write with byte 0xA2, data-write pointer byte, then data-write bytes. Each data byte is stored at the pointer, and the pointer then increments. At the stop event `wr_done` is high for exactly the next cycle. Event codes are: start 0, repeated start 1, stop 2, address-write 3, address-read 4, data-write 5, data-read 6.
- R4: A repeated start after the pointer byte begins a read. It must be followed by address-read with byte 0xA3. Each data-read byte is then stored at the pointer, which increments. At the stop event `rd_done` is high for exactly the next cycle.
- R5: Fields are packed in `field_bcd` one byte each, index 0 in bits 7:0. The order, with source register and mask, is: index 0 seconds (0x02, 0x7F), 1 minutes (0x03, 0x7F), 2 hours (0x04, 0x3F), 3 day (0x05, 0x3F), 4 weekday (0x06, 0x07), 5 month (0x07, 0x1F), 6 year (0x08, 0xFF).
- R6: Bit 7 of the byte stored at register 0x02 appears on `volt_low`.
- R7: Bits 4:0 of the byte stored at register 0x01 appear on `ctrl_flags[4:0]`. Bit 4 is timer repeat mode, bit 3 the alarm flag, bit 2 the timer flag, bit 1 the alarm interrupt enable and bit 0 the timer interrupt enable. Bits 7:5 are dropped.
- R8: If the address byte of an address-write does not equal 0xA2, the monitor returns to idle. Later data bytes and the stop then change nothing and raise no strobe.
- R9: `field_bin` holds, byte for byte, high nibble × 10 + low nibble of the matching `field_bcd` byte.
- R10: When a stored field holds a nibble above 9 after masking, `bcd_error` is set. It stays set until reset.
- R11: An accepted address-write (0xA2) clears all seven valid bits. Storing a field sets its bit in `field_vld`, which uses the same index as R5. A burst that covers only part of registers 0x02 to 0x08 still gives its stop strobe.
- R12: The pointer takes the low 4 bits of the pointer byte and wraps from 0x0F to 0x00. Registers 0x00 and 0x09 to 0x0F are accepted but change no output.
- R13: `wr_done` and `rd_done` are never high together and never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_valid | input | 1 | One-cycle qualifier for a decoded bus event |
| ev_code | input | 3 | Event code (see R3) |
| ev_data | input | 8 | Byte carried by an address or data event |
| field_bcd | output | 56 | Masked BCD time and date fields |
| field_bin | output | 56 | Binary equivalent of each field |
| field_vld | output | 7 | Per-field refreshed-in-this-transaction bits |
| volt_low | output | 1 | Captured voltage-low bit |
| ctrl_flags | output | 5 | Captured control register 2 bits |
| bcd_error | output | 1 | Sticky invalid-BCD indicator |
| wr_done | output | 1 | Write burst ended at stop |
| rd_done | output | 1 | Read burst ended at stop |

## Verification
Pointer wrap is the hardest case to reach from the ports. It shows only when a burst starts at pointer 0x0F and keeps going through two registers that change no output before it reaches the control register. The stimulus loads pointer 0x0F and sends two throwaway bytes and then a control byte. The control byte can reach `ctrl_flags` only if the pointer wrapped to 0x00 and then went on to 0x01. A read burst that covers only two fields follows a write of all fields, so the stimulus also shows that valid bits drop and untouched fields keep their old values.

// File: rtl/rtc_snoop_pkg.sv
package rtc_snoop_pkg;
   localparam int BYTE_W     = 8;
   localparam int NFIELD     = 7;
   localparam int FIELD_BASE = 2;
   localparam int CTRL_REG   = 1;
   localparam int CTRL_W     = 5;

   typedef enum logic [2:0] {
      EV_START   = 3'd0,
      EV_RSTART  = 3'd1,
      EV_STOP    = 3'd2,
      EV_ADDR_WR = 3'd3,
      EV_ADDR_RD = 3'd4,
      EV_DATA_WR = 3'd5,
      EV_DATA_RD = 3'd6
   } ev_code_t;

   typedef enum logic [2:0] {
      S_IDLE, S_ADDR, S_PTR, S_WR, S_RADDR, S_RD
   } snoop_st_t;

   function automatic logic [BYTE_W-1:0] field_mask(input int idx);
      case (idx)
         0, 1:    return 8'h7F;
         2, 3:    return 8'h3F;
         4:       return 8'h07;
         5:       return 8'h1F;
         default: return 8'hFF;
      endcase
   endfunction
endpackage

// File: rtl/rtc_snoop_seq.sv
module rtc_snoop_seq
   import rtc_snoop_pkg::*;
#(
   parameter int               PTR_W   = 4,
   parameter logic [BYTE_W-1:0] WR_ADDR = 8'hA2,
   parameter logic [BYTE_W-1:0] RD_ADDR = 8'hA3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_valid,
   input  logic [2:0]        ev_code,
   input  logic [BYTE_W-1:0] ev_data,
   output logic              st_en,
   output logic [PTR_W-1:0]  st_idx,
   output logic              clr_vld,
   output logic              wr_done,
   output logic              rd_done
);
   snoop_st_t        state;
   logic [PTR_W-1:0] ptr;

   // Storage is allowed in the two data phases only.
   assign st_en   = ev_valid &&
                    ((state == S_WR && ev_code == EV_DATA_WR) ||
                     (state == S_RD && ev_code == EV_DATA_RD));
   assign st_idx  = ptr;
   assign clr_vld = ev_valid && state == S_ADDR &&
                    ev_code == EV_ADDR_WR && ev_data == WR_ADDR;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         ptr     <= '0;
         wr_done <= 1'b0;
         rd_done <= 1'b0;
      end else begin
         wr_done <= 1'b0;
         rd_done <= 1'b0;
         if (ev_valid) begin
            if (ev_code == EV_STOP) begin
               wr_done <= (state == S_WR);
               rd_done <= (state == S_RD);
               state   <= S_IDLE;
            end else if (ev_code == EV_START) begin
               state <= S_ADDR;
            end else begin
               unique case (state)
                  S_ADDR:
                     if (ev_code == EV_ADDR_WR)
                        state <= (ev_data == WR_ADDR) ? S_PTR : S_IDLE;
                  S_PTR:
                     if (ev_code == EV_DATA_WR) begin
                        ptr   <= ev_data[PTR_W-1:0];
                        state <= S_WR;
                     end
                  S_WR:
                     if (ev_code == EV_RSTART)
                        state <= S_RADDR;
                     else if (ev_code == EV_DATA_WR)
                        ptr <= ptr + 1'b1;
                  S_RADDR:
                     if (ev_code == EV_ADDR_RD)
                        state <= (ev_data == RD_ADDR) ? S_RD : S_IDLE;
                  S_RD:
                     if (ev_code == EV_DATA_RD)
                        ptr <= ptr + 1'b1;
                  default: ;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/rtc_snoop_bank.sv
module rtc_snoop_bank
   import rtc_snoop_pkg::*;
#(
   parameter int PTR_W = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     st_en,
   input  logic [PTR_W-1:0]         st_idx,
   input  logic [BYTE_W-1:0]        st_data,
   input  logic                     clr_vld,
   output logic [NFIELD*BYTE_W-1:0] field_bcd,
   output logic [NFIELD-1:0]        field_vld,
   output logic                     volt_low,
   output logic [CTRL_W-1:0]        ctrl_flags,
   output logic                     bcd_error
);
   logic [NFIELD-1:0] bad_nib;

   for (genvar gi = 0; gi < NFIELD; gi++) begin : g_fld
      localparam logic [BYTE_W-1:0] MSK = field_mask(gi);
      logic              hit;
      logic [BYTE_W-1:0] masked;
      assign hit    = st_en && (st_idx == PTR_W'(FIELD_BASE + gi));
      assign masked = st_data & MSK;
      assign bad_nib[gi] = hit && (masked[7:4] > 4'd9 || masked[3:0] > 4'd9);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            field_bcd[gi*BYTE_W +: BYTE_W] <= '0;
            field_vld[gi]                  <= 1'b0;
         end else if (clr_vld) begin
            field_vld[gi] <= 1'b0;
         end else if (hit) begin
            field_bcd[gi*BYTE_W +: BYTE_W] <= masked;
            field_vld[gi]                  <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         volt_low   <= 1'b0;
         ctrl_flags <= '0;
         bcd_error  <= 1'b0;
      end else begin
         if (st_en && st_idx == PTR_W'(FIELD_BASE))
            volt_low <= st_data[BYTE_W-1];
         if (st_en && st_idx == PTR_W'(CTRL_REG))
            ctrl_flags <= st_data[CTRL_W-1:0];
         if (|bad_nib)
            bcd_error <= 1'b1;
      end
   end
endmodule

// File: rtl/rtc_snoop_bcd2bin.sv
module rtc_snoop_bcd2bin
   import rtc_snoop_pkg::*;
(
   input  logic [BYTE_W-1:0] bcd,
   output logic [BYTE_W-1:0] bin
);
   assign bin = BYTE_W'(bcd[7:4]) * BYTE_W'(10) + BYTE_W'(bcd[3:0]);
endmodule

// File: rtl/rtc_snoop.sv
module rtc_snoop
   import rtc_snoop_pkg::*;
#(
   parameter int                PTR_W   = 4,
   parameter logic [BYTE_W-1:0] WR_ADDR = 8'hA2,
   parameter logic [BYTE_W-1:0] RD_ADDR = 8'hA3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ev_valid,
   input  logic [2:0]               ev_code,
   input  logic [BYTE_W-1:0]        ev_data,
   output logic [NFIELD*BYTE_W-1:0] field_bcd,
   output logic [NFIELD*BYTE_W-1:0] field_bin,
   output logic [NFIELD-1:0]        field_vld,
   output logic                     volt_low,
   output logic [CTRL_W-1:0]        ctrl_flags,
   output logic                     bcd_error,
   output logic                     wr_done,
   output logic                     rd_done
);
   localparam int TOP_REG = FIELD_BASE + NFIELD - 1;

   if (PTR_W > BYTE_W || (1 << PTR_W) <= TOP_REG) begin : g_bad_ptr
      $error("rtc_snoop: PTR_W must address register %0d and fit a byte", TOP_REG);
   end
   if (WR_ADDR[0] != 1'b0 || RD_ADDR != (WR_ADDR | 8'h01)) begin : g_bad_addr
      $error("rtc_snoop: read address must be the write address with bit 0 set");
   end

   logic             st_en, clr_vld;
   logic [PTR_W-1:0] st_idx;

   rtc_snoop_seq #(.PTR_W(PTR_W), .WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR)) u_seq (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_code(ev_code),
      .ev_data(ev_data), .st_en(st_en), .st_idx(st_idx), .clr_vld(clr_vld),
      .wr_done(wr_done), .rd_done(rd_done)
   );

   rtc_snoop_bank #(.PTR_W(PTR_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .st_en(st_en), .st_idx(st_idx),
      .st_data(ev_data), .clr_vld(clr_vld), .field_bcd(field_bcd),
      .field_vld(field_vld), .volt_low(volt_low), .ctrl_flags(ctrl_flags),
      .bcd_error(bcd_error)
   );

   for (genvar gi = 0; gi < NFIELD; gi++) begin : g_conv
      rtc_snoop_bcd2bin u_conv (
         .bcd(field_bcd[gi*BYTE_W +: BYTE_W]),
         .bin(field_bin[gi*BYTE_W +: BYTE_W])
      );
   end
endmodule

// File: rtl/rtc_snoop_chk.sv
module rtc_snoop_chk
   import rtc_snoop_pkg::*;
(
   input logic                     clk,
   input logic                     rst_n,
   input logic                     ev_valid,
   input logic [2:0]               ev_code,
   input logic [NFIELD*BYTE_W-1:0] field_bcd,
   input logic [NFIELD-1:0]        field_vld,
   input logic                     bcd_error,
   input logic                     wr_done,
   input logic                     rd_done
);
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_done && rd_done)); // R13
   AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |=> !wr_done); // R13
   AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |=> !rd_done); // R13
   AST_STROBE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_done || rd_done) |-> $past(ev_valid && ev_code == EV_STOP)); // R3
   AST_BCDERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      bcd_error |=> bcd_error); // R10
   AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_valid |=> ($stable(field_bcd) && $stable(field_vld))); // R2
endmodule

bind rtc_snoop rtc_snoop_chk u_chk (
   .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_code(ev_code),
   .field_bcd(field_bcd), .field_vld(field_vld), .bcd_error(bcd_error),
   .wr_done(wr_done), .rd_done(rd_done)
);

// File: tb/sim_rtc_snoop.sv
`timescale 1ns/1ps
module sim_rtc_snoop;
   import rtc_snoop_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_valid = 1'b0;
   logic [2:0]  ev_code = 3'd0;
   logic [7:0]  ev_data = 8'd0;
   logic [55:0] field_bcd, field_bin;
   logic [6:0]  field_vld;
   logic        volt_low, bcd_error, wr_done, rd_done;
   logic [4:0]  ctrl_flags;

   int nchk = 0;
   int nfail = 0;
   int cyc = 0;
   bit done = 0;

   always #4 clk = ~clk;

   rtc_snoop u0 (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_code(ev_code),
      .ev_data(ev_data), .field_bcd(field_bcd), .field_bin(field_bin),
      .field_vld(field_vld), .volt_low(volt_low), .ctrl_flags(ctrl_flags),
      .bcd_error(bcd_error), .wr_done(wr_done), .rd_done(rd_done)
   );

   // Raw register bytes 0x02..0x08, register 0x02 in bits 7:0.
   localparam logic [55:0] VEC [4] = '{
      56'h99_12_06_31_23_30_59,
      56'h00_E9_FB_C1_E7_D8_C5,
      56'h24_01_00_15_00_00_00,
      56'hA5_01_01_01_01_01_01
   };
   localparam logic [7:0] MSK [7] = '{8'h7F, 8'h7F, 8'h3F, 8'h3F, 8'h07, 8'h1F, 8'hFF};

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic ev(input logic [2:0] c, input logic [7:0] d);
      @(negedge clk);
      ev_valid = 1'b1; ev_code = c; ev_data = d;
      @(negedge clk);
      ev_valid = 1'b0;
   endtask

   function automatic logic [7:0] b2i(input logic [7:0] b);
      return 8'(b[7:4] * 10 + b[3:0]);
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         nfail++;
         $display("TIMEOUT watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      logic err_exp;
      logic [55:0] snap;
      err_exp = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 field_bcd", field_bcd, 0);
      chk("R1 field_vld", field_vld, 0);
      chk("R1 flags", {volt_low, ctrl_flags, bcd_error, wr_done, rd_done}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 events before any start are ignored
      ev(EV_ADDR_WR, 8'hA2);
      ev(EV_DATA_WR, 8'h02);
      ev(EV_DATA_WR, 8'h45);
      ev(EV_STOP, 8'h00);
      chk("R2 no strobe", {wr_done, rd_done}, 0);
      chk("R2 field_bcd", field_bcd, 0);
      chk("R2 field_vld", field_vld, 0);

      // Table walk: full write bursts over registers 0x02..0x08 (R3 R5 R6 R9 R10 R11)
      foreach (VEC[v]) begin
         ev(EV_START, 8'h00);
         ev(EV_ADDR_WR, 8'hA2);
         ev(EV_DATA_WR, 8'h02);
         for (int f = 0; f < 7; f++) ev(EV_DATA_WR, VEC[v][f*8 +: 8]);
         ev(EV_STOP, 8'h00);
         chk("R3 wr_done", {wr_done, rd_done}, 2'b10);
         for (int f = 0; f < 7; f++) begin
            logic [7:0] m;
            m = VEC[v][f*8 +: 8] & MSK[f];
            if (m[7:4] > 9 || m[3:0] > 9) err_exp = 1'b1;
            chk($sformatf("R5 vec%0d field%0d", v, f), field_bcd[f*8 +: 8], m);
            chk($sformatf("R9 vec%0d field%0d", v, f), field_bin[f*8 +: 8], b2i(m));
         end
         chk("R6 volt_low", volt_low, VEC[v][7]);
         chk("R11 all valid", field_vld, 7'h7F);
         chk("R10 bcd_error", bcd_error, err_exp);
         @(negedge clk);
         chk("R13 wr_done one cycle", wr_done, 0);
      end

      // R4 R11 partial read burst: hour and day only
      snap = field_bcd;
      ev(EV_START, 8'h00);
      ev(EV_ADDR_WR, 8'hA2);
      ev(EV_DATA_WR, 8'h04);
      ev(EV_RSTART, 8'h00);
      ev(EV_ADDR_RD, 8'hA3);
      ev(EV_DATA_RD, 8'h12);
      ev(EV_DATA_RD, 8'h05);
      ev(EV_STOP, 8'h00);
      chk("R4 rd_done", {wr_done, rd_done}, 2'b01);
      chk("R4 hour", field_bcd[23:16], 8'h12);
      chk("R4 day", field_bcd[31:24], 8'h05);
      chk("R11 partial valid", field_vld, 7'b0001100);
      chk("R11 untouched minutes", field_bcd[15:8], snap[15:8]);
      chk("R10 still set", bcd_error, 1);
      @(negedge clk);
      chk("R13 rd_done one cycle", rd_done, 0);

      // R8 another slave is ignored
      snap = field_bcd;
      ev(EV_START, 8'h00);
      ev(EV_ADDR_WR, 8'hD0);
      ev(EV_DATA_WR, 8'h02);
      ev(EV_DATA_WR, 8'h33);
      ev(EV_STOP, 8'h00);
      chk("R8 no strobe", {wr_done, rd_done}, 0);
      chk("R8 fields kept", field_bcd, snap);
      chk("R8 valid kept", field_vld, 7'b0001100);

      // R7 control register 2
      ev(EV_START, 8'h00);
      ev(EV_ADDR_WR, 8'hA2);
      ev(EV_DATA_WR, 8'h01);
      ev(EV_DATA_WR, 8'hFB);
      ev(EV_STOP, 8'h00);
      chk("R7 ctrl_flags", ctrl_flags, 5'h1B);
      chk("R11 cleared by accepted address", field_vld, 0);

      // R12 pointer wrap 0x0F -> 0x00 -> 0x01
      snap = field_bcd;
      ev(EV_START, 8'h00);
      ev(EV_ADDR_WR, 8'hA2);
      ev(EV_DATA_WR, 8'hFF);
      ev(EV_DATA_WR, 8'hEE);
      ev(EV_DATA_WR, 8'h77);
      ev(EV_DATA_WR, 8'h05);
      ev(EV_STOP, 8'h00);
      chk("R12 wrap reaches ctrl", ctrl_flags, 5'h05);
      chk("R12 fields untouched", field_bcd, snap);
      chk("R12 wr_done", wr_done, 1);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule